// File: doc/BRIEF.md
# Event Engine Status and Control Register

This block holds the status word of a small command-executing event engine and makes it visible to a CPU over a 16-bit bus. The word has one engine-written bit, a condition flag, and seven bits that the CPU can change. Those seven are a buffer-bank select, an error-stop flag, a script-pending flag and four timer-pending flags. The engine updates the condition flag after every command it executes. It raises the error and pending flags and watches a halt output that follows the error flag directly.

The CPU never writes the status bits as plain values. Each write carries a set field and a clear field in one word. The low byte holds clear strobes for bits 6 to 0, and word bit 14 sets the bank select. The block also gives the CPU a 32-bit window onto the engine's 64-bit temporary buffer, and the bank select picks which half the window shows. The engine keeps its own direct view of the whole buffer.

Top module: `evstat_reg`

## Requirements
- R1: After reset every status bit is 0, the halt output is low, and a read of the status address returns 0x0000.
- R2: When the engine finishes a count-down or bit-test command (`eng_cmd_done`=1, `eng_cmd_test`=1) while not halted, status bit 7 takes the value of `eng_cmd_pass` on the next clock.
- R3: When the engine finishes any other command (`eng_cmd_test`=0) while not halted, status bit 7 is cleared. CPU writes never change bit 7.
- R4: Status bit 7 holds its value in cycles with no finished command. It also holds while the engine is halted, even if commands are reported.
- R5: `eng_err_set` sets status bit 5, and `eng_halt` equals bit 5. The bit stays set until a CPU write with word bit 5 = 1 clears it, and the halt output drops at the same time.
- R6: `eng_script_set` sets bit 4, and `eng_tmr_set[n]` sets bit n for n = 0..3. A CPU write with low-byte bit k = 1 clears status bit k (k = 0..5). The flags hold otherwise.
- R7: A hardware set of bits 5 to 0 in the same cycle as a CPU clear of the same bit leaves the bit set.
- R8: CPU write word bit 14 = 1 sets the bank select (status bit 6), and word bit 6 = 1 clears it. When both are 1 in one write, the bit ends up set.
- R9: Reads at address 2 return window bits 15:0 and reads at address 3 return window bits 31:16. The window is buffer bits 31:0 when the bank select is 0 and bits 63:32 when it is 1.
- R10: A status read (address 0) returns the eight status bits in bits 7:0 and zero in bits 15:8. Address 1 reads as 0. A byte-wide read (`cpu_wide`=0) returns zero in bits 15:8.
- R11: Byte-wide writes and writes to any address other than 0 change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| cpu_addr | input | 2 | 0 status, 1 reserved, 2 window low word, 3 window high word |
| cpu_wdata | input | 16 | Set/clear write word |
| cpu_rdata | output | 16 | Read data, combinational |
| eng_cmd_done | input | 1 | Engine finished a command this cycle |
| eng_cmd_test | input | 1 | Finished command was a count-down or bit-test |
| eng_cmd_pass | input | 1 | Pass/fail result of that command |
| eng_err_set | input | 1 | Engine detected an error |
| eng_script_set | input | 1 | Script event became pending |
| eng_tmr_set | input | 4 | Timer events became pending, one bit per timer |
| eng_tbuf | input | 64 | Engine temporary buffer contents |
| eng_halt | output | 1 | Engine must stay halted |
| eng_cflag | output | 1 | Condition flag for the next conditional command |

## Verification
A condition flag stuck at a wrong value shows on the status read and on `eng_cflag` one clock after the command that should have changed it. A lost error flag drops `eng_halt` in the same cycle. A wrong set/clear priority leaves a pending bit or the bank bit in the wrong state, and this is visible on the read that follows the colliding cycle. A wrong bank decode swaps the halves of a known buffer pattern on the very next window read, because read data is combinational.

// File: rtl/evstat_pkg.sv
package evstat_pkg;
  localparam int BUS_W   = 16;
  localparam int ADDR_W  = 2;
  localparam int NTMR    = 4;
  localparam int BUF_W   = 64;
  localparam int NFLAG   = NTMR + 2;   // timers, script, error
  localparam int ST_W    = 8;
  localparam int ST_COND = 7;
  localparam int ST_BANK = 6;
  localparam int ST_ERR  = 5;
  localparam int ST_SCR  = 4;
  localparam int WR_BANK_SET = 14;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_RSVD = 2'd1,
    A_WLO  = 2'd2,
    A_WHI  = 2'd3
  } evstat_addr_e;
endpackage

// File: rtl/evstat_cflag.sv
module evstat_cflag (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_done,
  input  logic cmd_test,
  input  logic cmd_pass,
  input  logic halted,
  output logic cflag
);
  logic cflag_en;
  logic cflag_d;

  always_comb begin
    cflag_en = cmd_done & ~halted;
    cflag_d  = cmd_test & cmd_pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cflag <= 1'b0;
    else if (cflag_en) cflag <= cflag_d;
  end

  a_r2_test_result: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !halted && cmd_test |=> cflag == $past(cmd_pass));
  a_r3_other_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !halted && !cmd_test |=> !cflag);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || !cmd_done) |=> $stable(cflag));
endmodule

// File: rtl/evstat_flags.sv
module evstat_flags #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] cpu_clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic d;
    logic en;
    always_comb begin
      en = hw_set[i] | cpu_clr[i];
      d  = hw_set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (en) q[i] <= d;
    end

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[i] |=> q[i]);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clr[i] && !hw_set[i] |=> !q[i]);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_clr[i] && q[i] |=> q[i]);
  end
endmodule

// File: rtl/evstat_bank.sv
module evstat_bank #(
  parameter int BUF_W = 64,
  localparam int HALF = BUF_W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic            clr,
  input  logic [BUF_W-1:0] tbuf,
  output logic            bank,
  output logic [HALF-1:0] window
);
  logic bank_en;
  logic bank_d;

  always_comb begin
    bank_en = set | clr;
    bank_d  = set;
    window  = bank ? tbuf[BUF_W-1:HALF] : tbuf[HALF-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank <= 1'b0;
    else if (bank_en) bank <= bank_d;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> bank);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !bank);
endmodule

// File: rtl/evstat_reg.sv
module evstat_reg
  import evstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_wide,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BUS_W-1:0]  cpu_wdata,
  output logic [BUS_W-1:0]  cpu_rdata,
  input  logic              eng_cmd_done,
  input  logic              eng_cmd_test,
  input  logic              eng_cmd_pass,
  input  logic              eng_err_set,
  input  logic              eng_script_set,
  input  logic [NTMR-1:0]   eng_tmr_set,
  input  logic [BUF_W-1:0]  eng_tbuf,
  output logic              eng_halt,
  output logic              eng_cflag
);
  localparam int HALF = BUF_W / 2;

  logic              wr_stat;
  logic [NFLAG-1:0]  flag_set;
  logic [NFLAG-1:0]  flag_clr;
  logic [NFLAG-1:0]  flag_q;
  logic              bank_set;
  logic              bank_clr;
  logic              bank_q;
  logic [HALF-1:0]   window;
  logic [ST_W-1:0]   status;
  logic              unused_wbits;

  assign unused_wbits = ^{cpu_wdata[BUS_W-1], cpu_wdata[WR_BANK_SET-1:ST_COND]};

  always_comb begin
    wr_stat  = cpu_sel & cpu_wr & cpu_wide & (cpu_addr == A_STAT);
    flag_set = {eng_err_set, eng_script_set, eng_tmr_set};
    flag_clr = wr_stat ? cpu_wdata[NFLAG-1:0] : '0;
    bank_set = wr_stat & cpu_wdata[WR_BANK_SET];
    bank_clr = wr_stat & cpu_wdata[ST_BANK];
  end

  evstat_cflag i_cflag (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_done (eng_cmd_done),
    .cmd_test (eng_cmd_test),
    .cmd_pass (eng_cmd_pass),
    .halted   (eng_halt),
    .cflag    (eng_cflag)
  );

  evstat_flags #(.W(NFLAG)) i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_set  (flag_set),
    .cpu_clr (flag_clr),
    .q       (flag_q)
  );

  evstat_bank #(.BUF_W(BUF_W)) i_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (bank_set),
    .clr    (bank_clr),
    .tbuf   (eng_tbuf),
    .bank   (bank_q),
    .window (window)
  );

  always_comb begin
    eng_halt = flag_q[ST_ERR];
    status   = {eng_cflag, bank_q, flag_q};
    cpu_rdata = '0;
    if (cpu_sel && !cpu_wr) begin
      case (cpu_addr)
        A_STAT:  cpu_rdata = {{(BUS_W-ST_W){1'b0}}, status};
        A_WLO:   cpu_rdata = window[BUS_W-1:0];
        A_WHI:   cpu_rdata = window[2*BUS_W-1:BUS_W];
        default: cpu_rdata = '0;
      endcase
      if (!cpu_wide) cpu_rdata[BUS_W-1:ST_W] = '0;
    end
  end

  a_r5_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_halt) |-> $past(eng_err_set));
  a_r11_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sel && cpu_wr && !cpu_wide && !eng_cmd_done && !eng_err_set &&
    !eng_script_set && (eng_tmr_set == '0) |=> $stable(status));
endmodule

// File: tb/test_evstat_reg.sv
module test_evstat_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n;
  logic        cpu_sel, cpu_wr, cpu_wide;
  logic [1:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        eng_cmd_done, eng_cmd_test, eng_cmd_pass;
  logic        eng_err_set, eng_script_set;
  logic [3:0]  eng_tmr_set;
  logic [63:0] eng_tbuf;
  logic        eng_halt, eng_cflag;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evstat_reg i_evstat_reg (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wide(cpu_wide), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .eng_cmd_done(eng_cmd_done),
    .eng_cmd_test(eng_cmd_test), .eng_cmd_pass(eng_cmd_pass),
    .eng_err_set(eng_err_set), .eng_script_set(eng_script_set),
    .eng_tmr_set(eng_tmr_set), .eng_tbuf(eng_tbuf),
    .eng_halt(eng_halt), .eng_cflag(eng_cflag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic wide, output logic [15:0] d);
    cpu_sel = 1; cpu_wr = 0; cpu_wide = wide; cpu_addr = a;
    #1 d = cpu_rdata;
    cpu_sel = 0;
  endtask

  task automatic chk_stat(input string req, input logic [7:0] exp);
    logic [15:0] d;
    rd(2'd0, 1'b1, d);
    chk(req, d, {8'h00, exp});
  endtask

  task automatic wr(input logic [1:0] a, input logic wide, input logic [15:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_wide = wide; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0; cpu_wide = 1;
  endtask

  task automatic cmd(input logic test, input logic pass);
    @(negedge clk);
    eng_cmd_done = 1; eng_cmd_test = test; eng_cmd_pass = pass;
    @(negedge clk);
    eng_cmd_done = 0; eng_cmd_test = 0; eng_cmd_pass = 0;
  endtask

  task automatic t_reset;
    chk_stat("R1 status after reset", 8'h00);
    chk("R1 halt after reset", {15'd0, eng_halt}, 16'd0);
  endtask

  task automatic t_cond;
    cmd(1, 1);
    chk_stat("R2 bit-test pass sets cond", 8'h80);
    chk("R2 cflag output", {15'd0, eng_cflag}, 16'd1);
    repeat (3) @(negedge clk);
    chk_stat("R4 cond holds when idle", 8'h80);
    wr(2'd0, 1, 16'h00FF);
    chk_stat("R3 cpu write leaves cond", 8'h80);
    cmd(0, 1);
    chk_stat("R3 other command clears cond", 8'h00);
    cmd(1, 0);
    chk_stat("R2 bit-test fail gives 0", 8'h00);
  endtask

  task automatic t_halt;
    cmd(1, 1);
    @(negedge clk); eng_err_set = 1;
    @(negedge clk); eng_err_set = 0;
    chk_stat("R5 error flag set", 8'hA0);
    chk("R5 halt high", {15'd0, eng_halt}, 16'd1);
    cmd(0, 0);
    chk_stat("R4 halted ignores command", 8'hA0);
    wr(2'd0, 1, 16'h0010);
    chk("R5 halt holds w/o err clear", {15'd0, eng_halt}, 16'd1);
    wr(2'd0, 1, 16'h0020);
    chk("R5 halt drops on clear", {15'd0, eng_halt}, 16'd0);
    chk_stat("R5 error cleared", 8'h80);
    cmd(0, 0);
    chk_stat("R3 resumed engine clears cond", 8'h00);
  endtask

  task automatic t_pending;
    @(negedge clk); eng_script_set = 1; eng_tmr_set = 4'b1010;
    @(negedge clk); eng_script_set = 0; eng_tmr_set = 4'b0000;
    chk_stat("R6 pending flags set", 8'h1A);
    wr(2'd0, 1, 16'h0008);
    chk_stat("R6 clear timer3 only", 8'h12);
    wr(2'd0, 0, 16'h00FF);
    chk_stat("R11 byte write ignored", 8'h12);
    wr(2'd2, 1, 16'h00FF);
    chk_stat("R11 other address write ignored", 8'h12);
    wr(2'd0, 1, 16'h0012);
    chk_stat("R6 clear script and timer1", 8'h00);
  endtask

  task automatic t_collide;
    @(negedge clk);
    eng_tmr_set = 4'b0001; eng_err_set = 1;
    cpu_sel = 1; cpu_wr = 1; cpu_wide = 1; cpu_addr = 0; cpu_wdata = 16'h4061;
    @(negedge clk);
    eng_tmr_set = 0; eng_err_set = 0; cpu_sel = 0; cpu_wr = 0;
    chk_stat("R7 R8 set wins over clear", 8'h61);
    wr(2'd0, 1, 16'h0061);
    chk_stat("R8 bank and flags cleared", 8'h00);
  endtask

  task automatic t_bank;
    logic [15:0] d;
    eng_tbuf = 64'h0123_4567_89AB_CDEF;
    rd(2'd2, 1, d); chk("R9 bank0 low word", d, 16'hCDEF);
    rd(2'd3, 1, d); chk("R9 bank0 high word", d, 16'h89AB);
    wr(2'd0, 1, 16'h4000);
    chk_stat("R8 bank set", 8'h40);
    rd(2'd2, 1, d); chk("R9 bank1 low word", d, 16'h4567);
    rd(2'd3, 1, d); chk("R9 bank1 high word", d, 16'h0123);
    rd(2'd3, 0, d); chk("R10 byte read upper zero", d, 16'h0023);
    rd(2'd1, 1, d); chk("R10 reserved address", d, 16'h0000);
    wr(2'd0, 1, 16'h0040);
    rd(2'd2, 1, d); chk("R8 R9 bank cleared", d, 16'hCDEF);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; cpu_sel = 0; cpu_wr = 0; cpu_wide = 1; cpu_addr = 0;
    cpu_wdata = 0; eng_cmd_done = 0; eng_cmd_test = 0; eng_cmd_pass = 0;
    eng_err_set = 0; eng_script_set = 0; eng_tmr_set = 0; eng_tbuf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cond;
    t_halt;
    t_pending;
    t_collide;
    t_bank;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule